// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sits above a single-attempt auxiliary-channel transaction engine and decides, attempt by attempt, whether a request is finished, must be retried, or has failed. When a request starts, it issues an attempt to the engine and waits for one result. The result is a timeout, an invalid reply, a hard error, or a decoded reply code with a returned byte count. Depending on that result, the block ends with success, ends with failure, or waits a set number of microsecond ticks and issues another attempt.

Each class of outcome has its own retry budget with its own counter. Native defers also build up a defer time in milliseconds, and a defer fails only when both the defer count and the accrued time have reached their limits. A timeout that comes after a defer is treated as a defer. A write that is acknowledged with a non-zero count turns later attempts into zero-length write-status polls. All waits are counted on `us_tick_i`, and the defer wait is programmable in milliseconds through `defer_ms_i`.

States: IDLE (waiting for `start_i`), ISSUE (one-cycle attempt request), AWAIT (waiting for `att_done_i`), DELAY (counting down the retry wait), FINISH (one-cycle done pulse). Transitions: IDLE→ISSUE on start; ISSUE→AWAIT always; AWAIT→DELAY on a retry decision; AWAIT→FINISH on success or failure; DELAY→ISSUE when the wait reaches zero; FINISH→IDLE always. A `start_i` seen outside IDLE is ignored.

Top module: `aux_retry_ctrl`

## Requirements
- R1: No request makes more than MAX_ATT attempts (default 7). A result that would otherwise cause a retry after the last allowed attempt ends the request in failure.
- R2: On a decoded ACK (outcome 0, reply 0) to a non-write attempt, a byte count different from the attempt length causes a retry after ACK_WAIT_US ticks (300). The ACK_LIMIT-th (7th) such reply fails the request.
- R3: On a decoded ACK to a write attempt with a non-zero count, the next attempt is issued after ACK_WAIT_US ticks as a status poll: `att_status_o`=1, `att_write_o`=0, `att_len_o`=0. The ACK_LIMIT-th such reply fails the request.
- R4: A native DEFER (outcome 0, reply 2) increments the defer count and adds POLL_MS to the accrued time. If the count is then at least DEFER_LIMIT (7) and the time is at least DEFER_MS_LIMIT (50), the request fails. Otherwise the block waits `defer_ms_i`×US_PER_MS ticks and adds `defer_ms_i` to the accrued time.
- R5: An I2C DEFER (outcome 0, reply 4) clears the native defer count and retries with no wait. The I2C_DEFER_LIMIT-th (7th) one fails the request.
- R6: A native NACK (reply 1), an I2C NACK (reply 3), an unknown reply code (5 to 7) or a hard error (outcome 3) fails the request after that attempt.
- R7: An invalid reply (outcome 2) causes a retry after INV_WAIT_US ticks (400). The INV_LIMIT-th (2nd) one fails the request.
- R8: A timeout (outcome 1) after any earlier native DEFER in the same request increments the defer count. It fails once the count reaches DEFER_LIMIT; otherwise it retries after `defer_ms_i`×US_PER_MS ticks.
- R9: A timeout with no earlier DEFER causes a retry with no wait. The TO_LIMIT-th (3rd) one fails the request.
- R10: Any decoded reply (outcome 0) clears the timeout count and the invalid-reply count.
- R11: `att_req_o` rises in the cycle after `start_i` is accepted. After a result, a retry's request comes W+2 cycles after the result cycle, where W is the wait in ticks (tick every cycle). `done_o` is a one-cycle pulse in the cycle after the final result.
- R12: A decoded ACK whose count matches the length (read), or whose count is zero (write or status poll), ends the request with `success_o`=1 together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a request (accepted in IDLE) |
| req_write_i | input | 1 | Request is a write |
| req_len_i | input | LEN_W | Request payload length in bytes |
| defer_ms_i | input | DMS_W | Defer wait in milliseconds |
| us_tick_i | input | 1 | One pulse per microsecond |
| att_req_o | output | 1 | One-cycle attempt request to the engine |
| att_write_o | output | 1 | Attempt is a write |
| att_status_o | output | 1 | Attempt is a write-status poll |
| att_len_o | output | LEN_W | Attempt length |
| att_done_i | input | 1 | Attempt result valid (one cycle) |
| att_outcome_i | input | 2 | 0 decoded, 1 timeout, 2 invalid, 3 hard error |
| att_reply_i | input | 3 | 0 ACK, 1 NACK, 2 DEFER, 3 I2C NACK, 4 I2C DEFER |
| att_count_i | input | LEN_W | Data bytes returned by the attempt |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| success_o | output | 1 | Request succeeded, valid with done_o |

## Verification
The first attempt request is due one cycle after `start_i`. `done_o` and `success_o` are due one cycle after the result that ends the request. A retry's request is due W+2 cycles after the result cycle, with W set by the outcome class (0, 300, 400 or the defer wait). The bench holds the tick high every cycle and drives the result at a falling edge. It then counts falling edges until it sees the next request or the done pulse, and compares that count with W+2 or 1, computed from the rules for every attempt in each scripted sequence. It also checks the final attempt count and the success flag against the count derived from the budgets, and checks the status-poll flag on each attempt.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

    typedef enum logic [1:0] {
        OUT_DECODED = 2'd0,
        OUT_TIMEOUT = 2'd1,
        OUT_INVALID = 2'd2,
        OUT_HARD    = 2'd3
    } outcome_e;

    localparam logic [2:0] RPL_ACK       = 3'd0;
    localparam logic [2:0] RPL_NACK      = 3'd1;
    localparam logic [2:0] RPL_DEFER     = 3'd2;
    localparam logic [2:0] RPL_I2C_NACK  = 3'd3;
    localparam logic [2:0] RPL_I2C_DEFER = 3'd4;

    typedef enum logic [1:0] {
        ACT_RETRY = 2'd0,
        ACT_SUCC  = 2'd1,
        ACT_FAIL  = 2'd2
    } action_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ISSUE  = 3'd1,
        S_AWAIT  = 3'd2,
        S_DELAY  = 3'd3,
        S_FINISH = 3'd4
    } state_e;

    localparam int CNT_SHORT = 0;
    localparam int CNT_ACKM  = 1;
    localparam int CNT_DEFER = 2;
    localparam int CNT_I2CD  = 3;
    localparam int CNT_INV   = 4;
    localparam int CNT_TO    = 5;
    localparam int NUM_CNT   = 6;

endpackage

// File: rtl/aux_retry_budget.sv
module aux_retry_budget #(
    parameter int CNT_W = 4,
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // True when one more increment reaches the budget
    assign last = (int'(cnt_q) + 1) >= LIMIT;
endmodule

// File: rtl/aux_retry_timer.sv
module aux_retry_timer #(
    parameter int WAIT_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              tick,
    output logic              zero
);
    logic [WAIT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (tick && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign zero = (left_q == '0);
endmodule

// File: rtl/aux_retry_decide.sv
module aux_retry_decide
    import aux_retry_pkg::*;
#(
    parameter int LEN_W          = 5,
    parameter int DMS_W          = 8,
    parameter int WAIT_W         = 18,
    parameter int ACC_W          = 6,
    parameter int DEFER_MS_LIMIT = 50,
    parameter int POLL_MS        = 4,
    parameter int US_PER_MS      = 1000,
    parameter int ACK_WAIT_US    = 300,
    parameter int INV_WAIT_US    = 400
) (
    input  outcome_e           outcome,
    input  logic [2:0]         reply,
    input  logic [LEN_W-1:0]   count,
    input  logic               cur_write,
    input  logic [LEN_W-1:0]   cur_len,
    input  logic [NUM_CNT-1:0] last,
    input  logic               seen_defer,
    input  logic [ACC_W-1:0]   acc_ms,
    input  logic [DMS_W-1:0]   defer_ms,
    input  logic               exhausted,
    output action_e            act,
    output logic [WAIT_W-1:0]  wait_us,
    output logic [NUM_CNT-1:0] inc,
    output logic [NUM_CNT-1:0] clr,
    output logic               go_status,
    output logic               set_seen,
    output logic [ACC_W-1:0]   acc_next
);
    logic [WAIT_W-1:0] defer_wait;
    int                sum1;
    int                sum2;

    assign defer_wait = WAIT_W'(int'(defer_ms) * US_PER_MS);

    always_comb begin
        act       = ACT_RETRY;
        wait_us   = '0;
        inc       = '0;
        clr       = '0;
        go_status = 1'b0;
        set_seen  = 1'b0;
        acc_next  = acc_ms;
        sum1      = int'(acc_ms) + POLL_MS;
        if (sum1 > DEFER_MS_LIMIT) sum1 = DEFER_MS_LIMIT;
        sum2      = sum1 + int'(defer_ms);
        if (sum2 > DEFER_MS_LIMIT) sum2 = DEFER_MS_LIMIT;
        unique case (outcome)
            OUT_DECODED: begin
                clr[CNT_TO]  = 1'b1;
                clr[CNT_INV] = 1'b1;
                case (reply)
                    RPL_ACK: begin
                        if (!cur_write && (count != cur_len)) begin
                            inc[CNT_SHORT] = 1'b1;
                            if (last[CNT_SHORT]) act = ACT_FAIL;
                            else wait_us = WAIT_W'(ACK_WAIT_US);
                        end else if (cur_write && (count != '0)) begin
                            inc[CNT_ACKM] = 1'b1;
                            if (last[CNT_ACKM]) begin
                                act = ACT_FAIL;
                            end else begin
                                go_status = 1'b1;
                                wait_us   = WAIT_W'(ACK_WAIT_US);
                            end
                        end else begin
                            act = ACT_SUCC;
                        end
                    end
                    RPL_DEFER: begin
                        inc[CNT_DEFER] = 1'b1;
                        set_seen       = 1'b1;
                        if (last[CNT_DEFER] && (sum1 >= DEFER_MS_LIMIT)) begin
                            act      = ACT_FAIL;
                            acc_next = ACC_W'(sum1);
                        end else begin
                            wait_us  = defer_wait;
                            acc_next = ACC_W'(sum2);
                        end
                    end
                    RPL_I2C_DEFER: begin
                        clr[CNT_DEFER] = 1'b1;
                        inc[CNT_I2CD]  = 1'b1;
                        if (last[CNT_I2CD]) act = ACT_FAIL;
                    end
                    default: act = ACT_FAIL;
                endcase
            end
            OUT_TIMEOUT: begin
                if (seen_defer) begin
                    inc[CNT_DEFER] = 1'b1;
                    if (last[CNT_DEFER]) act = ACT_FAIL;
                    else wait_us = defer_wait;
                end else begin
                    inc[CNT_TO] = 1'b1;
                    if (last[CNT_TO]) act = ACT_FAIL;
                end
            end
            OUT_INVALID: begin
                inc[CNT_INV] = 1'b1;
                if (last[CNT_INV]) act = ACT_FAIL;
                else wait_us = WAIT_W'(INV_WAIT_US);
            end
            OUT_HARD: act = ACT_FAIL;
        endcase
        if ((act == ACT_RETRY) && exhausted) begin
            act       = ACT_FAIL;
            go_status = 1'b0;
        end
    end
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
    import aux_retry_pkg::*;
#(
    parameter int LEN_W           = 5,
    parameter int DMS_W           = 8,
    parameter int MAX_ATT         = 7,
    parameter int ACK_LIMIT       = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int I2C_DEFER_LIMIT = 7,
    parameter int INV_LIMIT       = 2,
    parameter int TO_LIMIT        = 3,
    parameter int DEFER_MS_LIMIT  = 50,
    parameter int POLL_MS         = 4,
    parameter int US_PER_MS       = 1000,
    parameter int ACK_WAIT_US     = 300,
    parameter int INV_WAIT_US     = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             req_write_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic [DMS_W-1:0] defer_ms_i,
    input  logic             us_tick_i,
    output logic             att_req_o,
    output logic             att_write_o,
    output logic             att_status_o,
    output logic [LEN_W-1:0] att_len_o,
    input  logic             att_done_i,
    input  logic [1:0]       att_outcome_i,
    input  logic [2:0]       att_reply_i,
    input  logic [LEN_W-1:0] att_count_i,
    output logic             done_o,
    output logic             success_o
);
    localparam int ATT_W     = $clog2(MAX_ATT + 1) + 1;
    localparam int DEFER_MAX = ((1 << DMS_W) - 1) * US_PER_MS;
    localparam int FIX_MAX   = (ACK_WAIT_US > INV_WAIT_US) ? ACK_WAIT_US : INV_WAIT_US;
    localparam int WAIT_MAX  = (DEFER_MAX > FIX_MAX) ? DEFER_MAX : FIX_MAX;
    localparam int WAIT_W    = $clog2(WAIT_MAX + 1);
    localparam int ACC_W     = $clog2(DEFER_MS_LIMIT + 1);

    state_e             state_q;
    state_e             state_d;
    logic               cur_write_q;
    logic [LEN_W-1:0]   cur_len_q;
    logic               status_q;
    logic               seen_defer_q;
    logic [ACC_W-1:0]   acc_q;
    logic [ATT_W-1:0]   att_cnt_q;
    logic               succ_q;

    action_e            act;
    logic [WAIT_W-1:0]  wait_us;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0] cnt_clr;
    logic [NUM_CNT-1:0] cnt_last;
    logic               go_status;
    logic               set_seen;
    logic [ACC_W-1:0]   acc_next;
    logic               wait_zero;
    logic               accept;
    logic               result_seen;

    assign accept      = (state_q == S_IDLE) && start_i;
    assign result_seen = (state_q == S_AWAIT) && att_done_i;

    aux_retry_decide #(
        .LEN_W(LEN_W), .DMS_W(DMS_W), .WAIT_W(WAIT_W), .ACC_W(ACC_W),
        .DEFER_MS_LIMIT(DEFER_MS_LIMIT), .POLL_MS(POLL_MS),
        .US_PER_MS(US_PER_MS), .ACK_WAIT_US(ACK_WAIT_US), .INV_WAIT_US(INV_WAIT_US)
    ) u_decide (
        .outcome    (outcome_e'(att_outcome_i)),
        .reply      (att_reply_i),
        .count      (att_count_i),
        .cur_write  (cur_write_q),
        .cur_len    (cur_len_q),
        .last       (cnt_last),
        .seen_defer (seen_defer_q),
        .acc_ms     (acc_q),
        .defer_ms   (defer_ms_i),
        .exhausted  (int'(att_cnt_q) >= MAX_ATT),
        .act        (act),
        .wait_us    (wait_us),
        .inc        (cnt_inc),
        .clr        (cnt_clr),
        .go_status  (go_status),
        .set_seen   (set_seen),
        .acc_next   (acc_next)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_budget
        localparam int LIM = (g == CNT_SHORT) ? ACK_LIMIT :
                             (g == CNT_ACKM)  ? ACK_LIMIT :
                             (g == CNT_DEFER) ? DEFER_LIMIT :
                             (g == CNT_I2CD)  ? I2C_DEFER_LIMIT :
                             (g == CNT_INV)   ? INV_LIMIT : TO_LIMIT;
        aux_retry_budget #(.CNT_W(ATT_W), .LIMIT(LIM)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (accept),
            .clr     (result_seen && cnt_clr[g]),
            .inc     (result_seen && cnt_inc[g]),
            .last    (cnt_last[g])
        );
    end

    aux_retry_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (result_seen),
        .load_val (wait_us),
        .tick     (us_tick_i),
        .zero     (wait_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_ISSUE;
            S_ISSUE:  state_d = S_AWAIT;
            S_AWAIT:  if (att_done_i) state_d = (act == ACT_RETRY) ? S_DELAY : S_FINISH;
            S_DELAY:  if (wait_zero) state_d = S_ISSUE;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            cur_write_q  <= 1'b0;
            cur_len_q    <= '0;
            status_q     <= 1'b0;
            seen_defer_q <= 1'b0;
            acc_q        <= '0;
            att_cnt_q    <= '0;
            succ_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cur_write_q  <= req_write_i;
                cur_len_q    <= req_len_i;
                status_q     <= 1'b0;
                seen_defer_q <= 1'b0;
                acc_q        <= '0;
                att_cnt_q    <= '0;
                succ_q       <= 1'b0;
            end
            if (state_q == S_ISSUE) begin
                att_cnt_q <= att_cnt_q + 1'b1;
            end
            if (result_seen) begin
                acc_q  <= acc_next;
                succ_q <= (act == ACT_SUCC);
                if (set_seen) seen_defer_q <= 1'b1;
                if (go_status) begin
                    cur_write_q <= 1'b0;
                    cur_len_q   <= '0;
                    status_q    <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        att_req_o    = (state_q == S_ISSUE);
        att_write_o  = cur_write_q;
        att_status_o = status_q;
        att_len_o    = cur_len_q;
        done_o       = (state_q == S_FINISH);
        success_o    = (state_q == S_FINISH) && succ_q;
    end
endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk #(
    parameter int LEN_W   = 5,
    parameter int MAX_ATT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             att_req_o,
    input logic             att_write_o,
    input logic             att_status_o,
    input logic [LEN_W-1:0] att_len_o,
    input logic             att_done_i,
    input logic             done_o,
    input logic             success_o
);
    localparam int CW = $clog2(MAX_ATT + 1) + 1;
    logic [CW-1:0] reqs_q;
    logic          busy_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reqs_q <= '0;
            busy_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (done_o) reqs_q <= '0;
            else if (att_req_o && (reqs_q != {CW{1'b1}})) reqs_q <= reqs_q + 1'b1;
            if (done_o) busy_q <= 1'b0;
            else if (start_i) busy_q <= 1'b1;
            if (att_req_o) pend_q <= 1'b1;
            else if (att_done_i) pend_q <= 1'b0;
        end
    end

    p_attempt_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        att_req_o |-> (int'(reqs_q) < MAX_ATT));
    p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
        att_req_o |-> !pend_q);
    p_status_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        att_status_o |-> (!att_write_o && (att_len_o == '0)));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_start_issues_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q) |=> att_req_o);
    p_success_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        success_o |-> done_o);
endmodule

bind aux_retry_ctrl aux_retry_chk #(.LEN_W(LEN_W), .MAX_ATT(MAX_ATT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .att_req_o    (att_req_o),
    .att_write_o  (att_write_o),
    .att_status_o (att_status_o),
    .att_len_o    (att_len_o),
    .att_done_i   (att_done_i),
    .done_o       (done_o),
    .success_o    (success_o)
);

// File: tb/aux_retry_ctrl_tb.sv
module aux_retry_ctrl_tb;
    localparam int LEN_W = 5;
    localparam int DMS_W = 8;
    localparam int MAXA  = 12;
    localparam int USMS  = 10;
    localparam int POLL  = 5;
    localparam int WACK  = 300;
    localparam int WINV  = 400;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             req_write_i = 1'b0;
    logic [LEN_W-1:0] req_len_i = '0;
    logic [DMS_W-1:0] defer_ms_i = '0;
    logic             us_tick_i = 1'b1;
    logic             att_req_o, att_write_o, att_status_o;
    logic [LEN_W-1:0] att_len_o;
    logic             att_done_i = 1'b0;
    logic [1:0]       att_outcome_i = '0;
    logic [2:0]       att_reply_i = '0;
    logic [LEN_W-1:0] att_count_i = '0;
    logic             done_o, success_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int s_out [20];
    int s_rep [20];
    int s_cnt [20];
    int s_wt  [20];
    int s_st  [20];

    always #2.5 clk = ~clk;

    aux_retry_ctrl #(
        .LEN_W(LEN_W), .DMS_W(DMS_W), .MAX_ATT(MAXA),
        .POLL_MS(POLL), .US_PER_MS(USMS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_write_i(req_write_i),
        .req_len_i(req_len_i), .defer_ms_i(defer_ms_i), .us_tick_i(us_tick_i),
        .att_req_o(att_req_o), .att_write_o(att_write_o), .att_status_o(att_status_o),
        .att_len_o(att_len_o), .att_done_i(att_done_i), .att_outcome_i(att_outcome_i),
        .att_reply_i(att_reply_i), .att_count_i(att_count_i),
        .done_o(done_o), .success_o(success_o)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int n, input int o, input int r, input int c, input int w);
        for (int i = 0; i < n; i++) begin
            s_out[i] = o; s_rep[i] = r; s_cnt[i] = c; s_wt[i] = w; s_st[i] = 0;
        end
    endtask

    task automatic put(input int k, input int o, input int r, input int c, input int w);
        s_out[k] = o; s_rep[k] = r; s_cnt[k] = c; s_wt[k] = w;
    endtask

    task automatic run(input string tag, input bit wr, input int len, input int dms,
                       input int n_exp, input bit succ_exp);
        int k;
        int gap;
        bit fin;
        k = 0; gap = 0; fin = 0;
        @(negedge clk);
        defer_ms_i  = DMS_W'(dms);
        req_write_i = wr;
        req_len_i   = LEN_W'(len);
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        gap = 1;
        while (!fin) begin
            if (att_req_o) begin
                chk({tag, " request spacing (R11)"}, gap, (k == 0) ? 1 : s_wt[k] + 2);
                chk({tag, " status-poll flag (R3)"}, int'(att_status_o), s_st[k]);
                @(negedge clk);
                att_done_i    = 1'b1;
                att_outcome_i = 2'(s_out[k]);
                att_reply_i   = 3'(s_rep[k]);
                att_count_i   = LEN_W'(s_cnt[k]);
                @(negedge clk);
                att_done_i = 1'b0;
                gap = 1;
                if (done_o) begin
                    chk({tag, " attempts made (R1)"}, k + 1, n_exp);
                    chk({tag, " success flag (R12)"}, int'(success_o), int'(succ_exp));
                    fin = 1;
                end
                k = k + 1;
                if (!fin && k >= 20) begin
                    chk({tag, " runaway attempts (R1)"}, k, n_exp);
                    fin = 1;
                end
            end else begin
                @(negedge clk);
                gap = gap + 1;
                if (gap > 5000) begin
                    chk({tag, " no request or done (R11)"}, gap, 0);
                    fin = 1;
                end
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset done_o", int'(done_o), 0);
        chk("R11 reset att_req_o", int'(att_req_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12 full read and write ACK
        fill(1, 0, 0, 4, 0);  run("R12 read ok", 0, 4, 0, 1, 1);
        fill(1, 0, 0, 0, 0);  run("R12 write ok", 1, 3, 0, 1, 1);

        // R2 short reads
        fill(7, 0, 0, 2, WACK); run("R2 short x7", 0, 4, 0, 7, 0);
        fill(3, 0, 0, 2, WACK); put(2, 0, 0, 4, WACK); run("R2 short then full", 0, 4, 0, 3, 1);

        // R3 partial write then status poll
        fill(2, 0, 0, 1, WACK); put(1, 0, 0, 0, WACK); s_st[1] = 1;
        run("R3 write status poll", 1, 3, 0, 2, 1);

        // R6 immediate failures
        fill(1, 0, 1, 0, 0); run("R6 nack", 0, 2, 0, 1, 0);
        fill(1, 0, 3, 0, 0); run("R6 i2c nack", 0, 2, 0, 1, 0);
        fill(1, 0, 6, 0, 0); run("R6 unknown", 0, 2, 0, 1, 0);
        fill(1, 3, 0, 0, 0); run("R6 hard error", 0, 2, 0, 1, 0);

        // R7 invalid replies, R10 clearing by decoded reply
        fill(2, 2, 0, 0, WINV); put(1, 0, 0, 2, WINV); run("R7 invalid then ok", 0, 2, 0, 2, 1);
        fill(2, 2, 0, 0, WINV); run("R7 invalid x2", 0, 2, 0, 2, 0);
        fill(4, 2, 0, 0, WINV); put(1, 0, 0, 1, WINV); put(2, 2, 0, 0, WACK); put(3, 0, 0, 2, WINV);
        run("R10 invalid count cleared", 0, 2, 0, 4, 1);

        // R9 timeouts, R10 clearing
        fill(3, 1, 0, 0, 0); run("R9 timeout x3", 0, 2, 0, 3, 0);
        fill(6, 1, 0, 0, 0); put(2, 0, 0, 1, 0); put(3, 1, 0, 0, WACK); put(5, 0, 0, 2, 0);
        run("R10 timeout count cleared", 0, 2, 0, 6, 1);

        // R4 defers: count and time rule
        fill(12, 0, 2, 0, 0);      run("R4 defer dms0", 0, 2, 0, 10, 0);
        fill(12, 0, 2, 0, 2*USMS); run("R4 defer dms2", 0, 2, 2, 8, 0);
        fill(12, 0, 2, 0, 10*USMS); run("R4 defer dms10", 0, 2, 10, 7, 0);
        fill(2, 0, 2, 0, 3*USMS); put(1, 0, 0, 2, 3*USMS); run("R4 defer then ok", 0, 2, 3, 2, 1);

        // R8 timeouts after a defer
        fill(5, 1, 0, 0, USMS); put(0, 0, 2, 0, 0); put(4, 0, 0, 2, USMS);
        run("R8 timeouts as defers ok", 0, 2, 1, 5, 1);
        fill(7, 1, 0, 0, USMS); put(0, 0, 2, 0, 0); run("R8 defer limit", 0, 2, 1, 7, 0);

        // R5 i2c defers
        fill(7, 0, 4, 0, 0); run("R5 i2c defer x7", 0, 2, 0, 7, 0);
        // R5 clears native count; ends on attempt cap (R1) instead of attempt 11
        fill(12, 0, 2, 0, 0); put(6, 0, 4, 0, 0); run("R1 R5 cap after clear", 0, 2, 0, 12, 0);

        summary();
    end
endmodule